// File: doc/BRIEF.md
# Register-Mapped Parallel Port Adapter

The adapter sits between a small register bus on the host side and the lines of a classic printer-style parallel port. A host reads and writes three byte-wide registers, which occupy consecutive offsets. The data register drives eight data lines. The status register shows five peripheral inputs after synchronisation. The control register drives four handshake outputs, the data-line direction and an acknowledge interrupt enable.

Several bits differ in polarity from the pins they stand for, and the block handles each of these. The ready bit in the status byte is the inverse of the busy pin. Three of the control outputs are driven low when their register bit is 1. When the direction bit is set, the data drivers are released and the host reads the external levels. A falling edge on the acknowledge input can mark an interrupt as pending. The pending state drives a level interrupt output, shows up as a 0 in the status byte, and clears when the host reads status.

Top module: `par_port_ctrl`

## Requirements
- R1: Offset 0 selects data, offset 1 selects status and offset 2 selects control. Offset 3 reads 0x00, and a write to offset 3 changes nothing.
- R2: A write to offset 0 appears on `data_o` after the write edge. While bit 5 of control is 0, `data_oe_o` is 1 and a read of offset 0 returns the last value written.
- R3: While control bit 5 is 1, `data_oe_o` is 0 and a read of offset 0 returns `data_i`. A write to offset 0 in this mode is still stored, and it reads back once bit 5 returns to 0.
- R4: Status byte layout: bit 7 = NOT `busy_i`, bit 6 = `ack_ni`, bit 5 = `paper_out_i`, bit 4 = `online_i`, bit 3 = `fault_ni`, bit 2 = NOT pending, bits 1:0 = 0.
- R5: Each status input passes through two flip-flops. A change made before one rising edge is not yet visible in status after that edge. It is visible after the second edge.
- R6: Control bit 0 drives `strobe_no`, bit 1 drives `autofeed_no` and bit 3 drives `select_in_no`, each inverted, so writing 1 drives the pin to 0. Bit 2 drives `init_no` without inversion.
- R7: A read of offset 2 returns written bits 5:0, and bits 7:6 read 0. After reset, control holds 0x04, every output pin reads 1 and `irq_o` is 0.
- R8: While control bit 4 is 1, a synchronised falling edge of `ack_ni` sets pending. `irq_o` then goes to 1 and status bit 2 reads 0. While bit 4 is 0, the same edge has no effect.
- R9: Pending holds until offset 1 is read. From the next cycle, `irq_o` is 0 and status bit 2 reads 1. After reset, status bit 2 reads 1.
- R10: If an acknowledge edge and a status read fall in the same cycle, the read returns bit 2 = 1 and pending is set afterwards. The edge is not lost.
- R11: A write to offset 1 neither clears pending nor changes any status bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 2 | Register offset |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe (has side effects on status) |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, combinational from offset |
| data_o | output | 8 | Data lines, output value |
| data_oe_o | output | 1 | Data line output enable |
| data_i | input | 8 | Data lines, sensed level |
| busy_i | input | 1 | Peripheral busy |
| ack_ni | input | 1 | Acknowledge, active low |
| paper_out_i | input | 1 | Paper exhausted |
| online_i | input | 1 | Peripheral selected |
| fault_ni | input | 1 | Fault, active low |
| strobe_no | output | 1 | Data strobe, active low |
| autofeed_no | output | 1 | Auto line feed, active low |
| init_no | output | 1 | Peripheral initialise, active low |
| select_in_no | output | 1 | Select peripheral, active low |
| irq_o | output | 1 | Acknowledge interrupt level |

## Verification
Two things can happen in one cycle: the synchronised acknowledge edge sets pending, and a host read of the status register clears pending. The bench drives `ack_ni` low at a known falling clock edge. It counts the two synchronizer stages and issues the status read so that the read lands exactly on the edge that would set pending. It then checks three things: the returned byte still shows bit 2 as 1, `irq_o` is high in the next cycle, and a second read shows bit 2 as 0.

// File: rtl/ppa_pkg.sv
package ppa_pkg;
  localparam int REG_W = 8;
  localparam int CTRL_W = 6;

  localparam logic [1:0] OFF_DATA = 2'd0;
  localparam logic [1:0] OFF_STAT = 2'd1;
  localparam logic [1:0] OFF_CTRL = 2'd2;

  localparam int CB_STROBE = 0;
  localparam int CB_AFEED  = 1;
  localparam int CB_INIT   = 2;
  localparam int CB_SELIN  = 3;
  localparam int CB_IEN    = 4;
  localparam int CB_DIR    = 5;

  localparam logic [CTRL_W-1:0] CTRL_RST = 6'b000100;

  // sync vector order: {busy, ack_n, paper_out, online, fault_n}
  localparam int ST_N = 5;
  localparam logic [ST_N-1:0] ST_RST = 5'b01001;
endpackage

// File: rtl/ppa_sync.sv
module ppa_sync #(
  parameter int W = 1,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg [STAGES];

  for (genvar i = 0; i < STAGES; i++) begin : g_stg
    if (i == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) stg[i] <= RST_VAL;
        else         stg[i] <= d_i;
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) stg[i] <= RST_VAL;
        else         stg[i] <= stg[i-1];
    end
  end

  assign q_o = stg[STAGES-1];
endmodule

// File: rtl/ppa_ack_irq.sv
module ppa_ack_irq (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ack_n_i,   // already synchronised
  input  logic ien_i,
  input  logic clr_i,
  output logic ack_fall_o,
  output logic pending_o
);
  logic ack_prev_q;
  logic pend_q;

  assign ack_fall_o = ack_prev_q & ~ack_n_i;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) ack_prev_q <= 1'b1;
    else         ack_prev_q <= ack_n_i;

  // a new edge takes precedence over a clearing read
  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)                  pend_q <= 1'b0;
    else if (ack_fall_o && ien_i) pend_q <= 1'b1;
    else if (clr_i)               pend_q <= 1'b0;

  assign pending_o = pend_q;
endmodule

// File: rtl/par_port_ctrl.sv
module par_port_ctrl
  import ppa_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [1:0]       addr_i,
  input  logic             wr_en_i,
  input  logic             rd_en_i,
  input  logic [REG_W-1:0] wdata_i,
  output logic [REG_W-1:0] rdata_o,
  output logic [REG_W-1:0] data_o,
  output logic             data_oe_o,
  input  logic [REG_W-1:0] data_i,
  input  logic             busy_i,
  input  logic             ack_ni,
  input  logic             paper_out_i,
  input  logic             online_i,
  input  logic             fault_ni,
  output logic             strobe_no,
  output logic             autofeed_no,
  output logic             init_no,
  output logic             select_in_no,
  output logic             irq_o
);
  logic [REG_W-1:0]  data_q;
  logic [CTRL_W-1:0] ctrl_q;
  logic [ST_N-1:0]   st_raw, st_sync;
  logic              busy_s, ack_n_s, pout_s, online_s, fault_n_s;
  logic              ack_fall, pending, stat_rd;

  assign st_raw = {busy_i, ack_ni, paper_out_i, online_i, fault_ni};

  ppa_sync #(.W(ST_N), .STAGES(SYNC_STAGES), .RST_VAL(ST_RST)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (st_raw),
    .q_o   (st_sync)
  );

  assign {busy_s, ack_n_s, pout_s, online_s, fault_n_s} = st_sync;

  assign stat_rd = rd_en_i && (addr_i == OFF_STAT);

  ppa_ack_irq u_irq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .ack_n_i   (ack_n_s),
    .ien_i     (ctrl_q[CB_IEN]),
    .clr_i     (stat_rd),
    .ack_fall_o(ack_fall),
    .pending_o (pending)
  );

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)                              data_q <= '0;
    else if (wr_en_i && addr_i == OFF_DATA)   data_q <= wdata_i;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)                              ctrl_q <= CTRL_RST;
    else if (wr_en_i && addr_i == OFF_CTRL)   ctrl_q <= wdata_i[CTRL_W-1:0];

  always_comb begin
    unique case (addr_i)
      OFF_DATA: rdata_o = ctrl_q[CB_DIR] ? data_i : data_q;
      OFF_STAT: rdata_o = {~busy_s, ack_n_s, pout_s, online_s, fault_n_s, ~pending, 2'b00};
      OFF_CTRL: rdata_o = {{(REG_W-CTRL_W){1'b0}}, ctrl_q};
      default:  rdata_o = '0;
    endcase
  end

  assign data_o       = data_q;
  assign data_oe_o    = ~ctrl_q[CB_DIR];
  assign strobe_no    = ~ctrl_q[CB_STROBE];
  assign autofeed_no  = ~ctrl_q[CB_AFEED];
  assign init_no      =  ctrl_q[CB_INIT];
  assign select_in_no = ~ctrl_q[CB_SELIN];
  assign irq_o        = pending;
endmodule

// File: rtl/par_port_ctrl_chk.sv
module par_port_ctrl_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic [1:0] addr_i,
  input logic       wr_en_i,
  input logic       rd_en_i,
  input logic [7:0] wdata_i,
  input logic [7:0] rdata_o,
  input logic [7:0] data_o,
  input logic       data_oe_o,
  input logic       strobe_no,
  input logic       init_no,
  input logic       irq_o,
  input logic       ack_fall
);
  AST_DATA_WR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == 2'd0) |=> data_o == $past(wdata_i)); // R2

  AST_DIR_OE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == 2'd2) |=> data_oe_o == !$past(wdata_i[5])); // R3

  AST_STROBE_INV: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == 2'd2) |=> strobe_no == !$past(wdata_i[0])); // R6

  AST_INIT_DIRECT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == 2'd2) |=> init_no == $past(wdata_i[2])); // R6

  AST_CTRL_TOP_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == 2'd2) |-> rdata_o[7:6] == 2'b00); // R7

  AST_RSV_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == 2'd1) |-> rdata_o[1:0] == 2'b00); // R4

  AST_IRQ_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && addr_i == 2'd1 && !ack_fall) |=> !irq_o); // R9

  AST_IRQ_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && !(rd_en_i && addr_i == 2'd1)) |=> irq_o); // R9

  AST_EDGE_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && ack_fall) |=> irq_o); // R10
endmodule

bind par_port_ctrl par_port_ctrl_chk u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .addr_i   (addr_i),
  .wr_en_i  (wr_en_i),
  .rd_en_i  (rd_en_i),
  .wdata_i  (wdata_i),
  .rdata_o  (rdata_o),
  .data_o   (data_o),
  .data_oe_o(data_oe_o),
  .strobe_no(strobe_no),
  .init_no  (init_no),
  .irq_o    (irq_o),
  .ack_fall (ack_fall)
);

// File: tb/par_port_ctrl_bench.sv
`timescale 1ns/1ps
module par_port_ctrl_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] addr = '0;
  logic       wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0] wdata = '0, rdata, data_o, data_in = '0;
  logic       data_oe, busy = 1'b0, ack_n = 1'b1, pout = 1'b0, online = 1'b1, fault_n = 1'b1;
  logic       strobe_n, afeed_n, init_n, selin_n, irq;

  int total = 0;
  int bad = 0;
  int cycles = 0;

  typedef struct {
    logic [7:0] exp;
    string      tag;
  } item_t;
  item_t sb_q[$];

  always #4 clk = ~clk;

  par_port_ctrl u_par_port_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wr_en_i(wr_en), .rd_en_i(rd_en),
    .wdata_i(wdata), .rdata_o(rdata), .data_o(data_o), .data_oe_o(data_oe),
    .data_i(data_in), .busy_i(busy), .ack_ni(ack_n), .paper_out_i(pout),
    .online_i(online), .fault_ni(fault_n), .strobe_no(strobe_n),
    .autofeed_no(afeed_n), .init_no(init_n), .select_in_no(selin_n), .irq_o(irq)
  );

  task automatic report();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      total++; bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      report();
    end
  end

  // monitor: compare read data a quarter period after the driving edge
  always @(negedge clk) begin
    #2;
    if (rd_en) begin
      item_t it;
      total++;
      if (sb_q.size() == 0) begin
        bad++;
        $display("FAIL scoreboard: actual=unexpected read expected=queued item");
      end else begin
        it = sb_q.pop_front();
        if (rdata !== it.exp) begin
          bad++;
          $display("FAIL %s: actual=%02h expected=%02h", it.tag, rdata, it.exp);
        end
      end
    end
  end

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  // all bus tasks start and end at a falling edge
  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, input logic [7:0] e, input string tag);
    item_t it;
    it.exp = e; it.tag = tag;
    sb_q.push_back(it);
    addr = a; rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    idle(2);
    rst_n = 1'b1;
    @(negedge clk);
    #2;
    chk("R7 reset pins", {3'b0, strobe_n, afeed_n, init_n, selin_n, data_oe}, 8'h1F);
    chk("R7 reset irq", {7'b0, irq}, 8'h00);
    @(negedge clk);
    rd(2'd2, 8'h04, "R7 reset ctrl");
    rd(2'd1, 8'hDC, "R9 reset status");

    wr(2'd0, 8'hA5);
    #2 chk("R2 data pins", data_o, 8'hA5);
    @(negedge clk);
    rd(2'd0, 8'hA5, "R2 data readback");

    wr(2'd2, 8'h0F);
    #2 chk("R6 pins ctrl=0F", {4'b0, strobe_n, afeed_n, init_n, selin_n}, 8'h02);
    @(negedge clk);
    wr(2'd2, 8'h00);
    #2 chk("R6 pins ctrl=00", {4'b0, strobe_n, afeed_n, init_n, selin_n}, 8'h0D);
    @(negedge clk);
    wr(2'd2, 8'hFF);
    rd(2'd2, 8'h3F, "R7 ctrl top bits zero");

    data_in = 8'h3C;
    #2 chk("R3 oe released", {7'b0, data_oe}, 8'h00);
    @(negedge clk);
    rd(2'd0, 8'h3C, "R3 input read");
    wr(2'd0, 8'h11);
    wr(2'd2, 8'h04);
    #2 chk("R3 oe restored", {7'b0, data_oe}, 8'h01);
    @(negedge clk);
    rd(2'd0, 8'h11, "R3 stored while input");

    busy = 1'b1; pout = 1'b1; online = 1'b0; fault_n = 1'b0;
    rd(2'd1, 8'hDC, "R5 zero edges");
    rd(2'd1, 8'hDC, "R5 one edge");
    rd(2'd1, 8'h64, "R4 status map");
    busy = 1'b0; pout = 1'b0; online = 1'b1; fault_n = 1'b1;
    idle(3);

    ack_n = 1'b0; idle(4); ack_n = 1'b1; idle(4);
    chk("R8 disabled no irq", {7'b0, irq}, 8'h00);
    rd(2'd1, 8'hDC, "R8 disabled flag");

    wr(2'd2, 8'h14);
    ack_n = 1'b0; idle(4); ack_n = 1'b1; idle(4);
    #2 chk("R8 irq set", {7'b0, irq}, 8'h01);
    @(negedge clk);
    wr(2'd1, 8'h00);
    #2 chk("R11 status write keeps irq", {7'b0, irq}, 8'h01);
    @(negedge clk);
    rd(2'd1, 8'hD8, "R8 flag low");
    #2 chk("R9 irq cleared", {7'b0, irq}, 8'h00);
    @(negedge clk);
    rd(2'd1, 8'hDC, "R9 flag back");

    ack_n = 1'b0;
    idle(2);
    rd(2'd1, 8'h9C, "R10 read on edge cycle");
    #2 chk("R10 irq survives", {7'b0, irq}, 8'h01);
    @(negedge clk);
    rd(2'd1, 8'h98, "R10 flag pending");
    ack_n = 1'b1;
    idle(3);

    wr(2'd3, 8'hFF);
    rd(2'd3, 8'h00, "R1 offset 3 zero");
    rd(2'd2, 8'h14, "R1 ctrl untouched");
    rd(2'd0, 8'h11, "R1 data untouched");
    idle(2);

    total++;
    if (sb_q.size() != 0) begin
      bad++;
      $display("FAIL scoreboard drain: actual=%0d expected=0", sb_q.size());
    end
    report();
  end
endmodule